// File: doc/BRIEF.md
# JTAG Configuration Loader TAP

This block is a test access port controller for a programmable logic device. The configuration image is loaded through the four JTAG pins. It contains the sixteen-state TMS-driven controller, a 5-bit instruction register and a one-bit bypass register. Two private instructions extend it:

- **Load instruction.** While it is active, the serial stream that arrives on TDI during Shift-DR is packed into bytes. Each completed byte is handed to the internal configuration bus with a single-cycle strobe.
- **Start instruction.** While it is active, every TCK cycle spent in Shift-DR is passed on as one step of the start-up sequence.

A host uses the block in two phases. To configure the device, it loads the load instruction, enters Shift-DR, streams the image and returns to Run-Test-Idle. To start the device, it loads the start instruction, enters Shift-DR, holds there for as many TCK cycles as the start-up sequence needs, and returns to Run-Test-Idle.

An active-low program pin holds the whole port in reset. Three mode pins are decoded to report when the device strap selects JTAG configuration. The TAP itself works whatever the strap value is.

Top module: `jcp_top`

## Requirements
- R1: While `prog_ni` is low, the port is held in Test-Logic-Reset. During that time `tdo_o`, `pkt_valid_o` and `startup_en_o` stay low and TMS/TDI activity has no effect. After release, the selected instruction is bypass and no partial byte remains.
- R2: The controller follows the IEEE 1149.1 TMS transitions, sampled on rising TCK. Five consecutive TMS-high cycles reach Test-Logic-Reset from any state, including Pause-DR.
- R3: The instruction register is 5 bits wide and is shifted LSB first from TDI toward TDO in Shift-IR. Capture-IR loads 00001, so the first bit out is 1 and the next four are 0. The new instruction takes effect on the rising edge that leaves Update-IR.
- R4: Test-Logic-Reset selects the bypass instruction and empties the partial-byte counter.
- R5: When bypass is selected, Capture-DR clears the 1-bit bypass register. In Shift-DR, `tdo_o` then shows a 0 first and after that the TDI bit of the previous TCK cycle. BYPASS is opcode 11111.
- R6: With the load instruction (opcode 00101) selected, each Shift-DR rising edge takes one TDI bit. Bits are packed MSB first. On the eighth bit, `pkt_byte_o` carries the byte and `pkt_valid_o` is high for exactly one cycle. A partial byte is kept across a Pause-DR excursion.
- R7: `pkt_valid_o` never rises under any instruction other than the load instruction, and never outside Shift-DR.
- R8: `startup_en_o` is high exactly in the cycles in which the controller is in Shift-DR with the start instruction (opcode 01100) selected.
- R9: `bscan_mode_o` is high when `mode_i` (M2..M0) equals 101 or 001, and low for the other six values. Configuration loading works for any `mode_i` value.
- R10: `tdo_o` is low outside Shift-IR and Shift-DR. It is also low in Shift-DR while the load or start instruction is selected.
- R11: Any opcode other than load or start behaves as bypass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| prog_ni | input | 1 | Active-low program pin, holds the TAP in reset |
| mode_i | input | 3 | Mode strap pins {M2,M1,M0} |
| tms_i | input | 1 | Test mode select |
| tdi_i | input | 1 | Test data in |
| tdo_o | output | 1 | Test data out |
| pkt_valid_o | output | 1 | One-cycle strobe for a completed configuration byte |
| pkt_byte_o | output | 8 | Completed configuration byte |
| startup_en_o | output | 1 | Start-up step enable, one step per TCK cycle |
| bscan_mode_o | output | 1 | Mode pins select JTAG configuration |

## Verification
Several distinct byte streams are sent to the packer:
- Contiguous bytes of alternating bits, all-ones and all-zeros expose bit-order and packing errors.
- A byte split by a Pause-DR excursion separates a counter that is retained from one that is reset on leaving Shift-DR.
- A few bits shifted before a program pulse or a five-TMS-high reset, followed by a fresh load, show whether the counter really empties. A leftover count would misalign the next byte.

Bypass patterns are shifted under the BYPASS opcode, under an undefined opcode and straight after reset. These runs tell apart instruction-register decode faults and a missing reset of the instruction register. A start-instruction run counts the enable cycles against the Shift-DR dwell.

// File: rtl/jcp_pkg.sv
package jcp_pkg;

  localparam int unsigned IR_W = 5;

  localparam logic [IR_W-1:0] OP_BYPASS  = 5'b11111;
  localparam logic [IR_W-1:0] OP_CFG     = 5'b00101;
  localparam logic [IR_W-1:0] OP_START   = 5'b01100;
  localparam logic [IR_W-1:0] IR_CAPTURE = 5'b00001;

  typedef enum logic [3:0] {
    TS_RESET   = 4'h0,
    TS_IDLE    = 4'h1,
    TS_SEL_DR  = 4'h2,
    TS_CAP_DR  = 4'h3,
    TS_SH_DR   = 4'h4,
    TS_EX1_DR  = 4'h5,
    TS_PAU_DR  = 4'h6,
    TS_EX2_DR  = 4'h7,
    TS_UPD_DR  = 4'h8,
    TS_SEL_IR  = 4'h9,
    TS_CAP_IR  = 4'hA,
    TS_SH_IR   = 4'hB,
    TS_EX1_IR  = 4'hC,
    TS_PAU_IR  = 4'hD,
    TS_EX2_IR  = 4'hE,
    TS_UPD_IR  = 4'hF
  } tap_state_e;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
    unique case (s)
      TS_RESET:  return tms ? TS_RESET  : TS_IDLE;
      TS_IDLE:   return tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_DR: return tms ? TS_SEL_IR : TS_CAP_DR;
      TS_CAP_DR: return tms ? TS_EX1_DR : TS_SH_DR;
      TS_SH_DR:  return tms ? TS_EX1_DR : TS_SH_DR;
      TS_EX1_DR: return tms ? TS_UPD_DR : TS_PAU_DR;
      TS_PAU_DR: return tms ? TS_EX2_DR : TS_PAU_DR;
      TS_EX2_DR: return tms ? TS_UPD_DR : TS_SH_DR;
      TS_UPD_DR: return tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_IR: return tms ? TS_RESET  : TS_CAP_IR;
      TS_CAP_IR: return tms ? TS_EX1_IR : TS_SH_IR;
      TS_SH_IR:  return tms ? TS_EX1_IR : TS_SH_IR;
      TS_EX1_IR: return tms ? TS_UPD_IR : TS_PAU_IR;
      TS_PAU_IR: return tms ? TS_EX2_IR : TS_PAU_IR;
      TS_EX2_IR: return tms ? TS_UPD_IR : TS_SH_IR;
      default:   return tms ? TS_SEL_DR : TS_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/jcp_tap_fsm.sv
module jcp_tap_fsm
  import jcp_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tms_i,
  output tap_state_e state_o
);

  tap_state_e state_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= TS_RESET;
    else         state_q <= tap_next(state_q, tms_i);
  end

  assign state_o = state_q;

endmodule

// File: rtl/jcp_ir.sv
module jcp_ir
  import jcp_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  tap_state_e state_i,
  input  logic       tdi_i,
  output logic       ir_tdo_o,
  output logic       sel_cfg_o,
  output logic       sel_start_o,
  output logic       sel_bypass_o
);

  logic [IR_W-1:0] shift_q;
  logic [IR_W-1:0] ir_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= IR_CAPTURE;
      ir_q    <= OP_BYPASS;
    end else begin
      unique case (state_i)
        TS_RESET:  ir_q    <= OP_BYPASS;
        TS_CAP_IR: shift_q <= IR_CAPTURE;
        TS_SH_IR:  shift_q <= {tdi_i, shift_q[IR_W-1:1]};
        TS_UPD_IR: ir_q    <= shift_q;
        default: ;
      endcase
    end
  end

  // undefined opcodes fall back to bypass
  always_comb begin
    sel_cfg_o    = (ir_q == OP_CFG);
    sel_start_o  = (ir_q == OP_START);
    sel_bypass_o = !(sel_cfg_o || sel_start_o);
  end

  assign ir_tdo_o = shift_q[0];

endmodule

// File: rtl/jcp_dr_path.sv
module jcp_dr_path
  import jcp_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  tap_state_e        state_i,
  input  logic              sel_cfg_i,
  input  logic              sel_start_i,
  input  logic              tdi_i,
  output logic              byp_tdo_o,
  output logic              pkt_valid_o,
  output logic [BYTE_W-1:0] pkt_byte_o,
  output logic              startup_en_o
);

  localparam int unsigned CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  logic              byp_q;
  logic [BYTE_W-2:0] acc_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              vld_q;
  logic [BYTE_W-1:0] byte_q;
  logic              shifting;

  assign shifting = (state_i == TS_SH_DR);

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byp_q  <= 1'b0;
      acc_q  <= '0;
      cnt_q  <= '0;
      vld_q  <= 1'b0;
      byte_q <= '0;
    end else begin
      vld_q <= 1'b0;
      if (state_i == TS_RESET) cnt_q <= '0;
      if (state_i == TS_CAP_DR) byp_q <= 1'b0;
      if (shifting) begin
        byp_q <= tdi_i;
        if (sel_cfg_i) begin
          acc_q <= {acc_q[BYTE_W-3:0], tdi_i};
          if (cnt_q == CNT_LAST) begin
            vld_q  <= 1'b1;
            byte_q <= {acc_q, tdi_i};
            cnt_q  <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  assign byp_tdo_o    = byp_q;
  assign pkt_valid_o  = vld_q;
  assign pkt_byte_o   = byte_q;
  assign startup_en_o = shifting && sel_start_i;

endmodule

// File: rtl/jcp_top.sv
module jcp_top
  import jcp_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic              prog_ni,
  input  logic [2:0]        mode_i,
  input  logic              tms_i,
  input  logic              tdi_i,
  output logic              tdo_o,
  output logic              pkt_valid_o,
  output logic [BYTE_W-1:0] pkt_byte_o,
  output logic              startup_en_o,
  output logic              bscan_mode_o
);

  tap_state_e tap_state;
  logic       tap_rst_n;
  logic       ir_tdo;
  logic       byp_tdo;
  logic       sel_cfg;
  logic       sel_start;
  logic       sel_bypass;

  // program pin acts as a second asynchronous reset source
  assign tap_rst_n = rst_ni & prog_ni;

  jcp_tap_fsm i_fsm (
    .tck_i   (tck_i),
    .rst_ni  (tap_rst_n),
    .tms_i   (tms_i),
    .state_o (tap_state)
  );

  jcp_ir i_ir (
    .tck_i        (tck_i),
    .rst_ni       (tap_rst_n),
    .state_i      (tap_state),
    .tdi_i        (tdi_i),
    .ir_tdo_o     (ir_tdo),
    .sel_cfg_o    (sel_cfg),
    .sel_start_o  (sel_start),
    .sel_bypass_o (sel_bypass)
  );

  jcp_dr_path #(.BYTE_W(BYTE_W)) i_dr (
    .tck_i        (tck_i),
    .rst_ni       (tap_rst_n),
    .state_i      (tap_state),
    .sel_cfg_i    (sel_cfg),
    .sel_start_i  (sel_start),
    .tdi_i        (tdi_i),
    .byp_tdo_o    (byp_tdo),
    .pkt_valid_o  (pkt_valid_o),
    .pkt_byte_o   (pkt_byte_o),
    .startup_en_o (startup_en_o)
  );

  always_comb begin
    tdo_o = 1'b0;
    if (tap_state == TS_SH_IR)                    tdo_o = ir_tdo;
    else if (tap_state == TS_SH_DR && sel_bypass) tdo_o = byp_tdo;
  end

  assign bscan_mode_o = (mode_i == 3'b101) || (mode_i == 3'b001);

endmodule

// File: rtl/jcp_chk.sv
module jcp_chk
  import jcp_pkg::*;
(
  input logic       tck_i,
  input logic       rst_ni,
  input logic       prog_ni,
  input logic       tdo_o,
  input logic       pkt_valid_o,
  input logic       startup_en_o,
  input tap_state_e tap_state,
  input logic       sel_cfg,
  input logic       sel_bypass
);

  // R1
  prog_hold_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !prog_ni |-> (tap_state == TS_RESET && !pkt_valid_o && !startup_en_o && !tdo_o));

  // R4
  tlr_bypass_chk: assert property (@(posedge tck_i) disable iff (!rst_ni || !prog_ni)
    (tap_state == TS_RESET) |=> sel_bypass);

  // R6
  pkt_pulse_chk: assert property (@(posedge tck_i) disable iff (!rst_ni || !prog_ni)
    pkt_valid_o |=> !pkt_valid_o);

  // R7
  pkt_source_chk: assert property (@(posedge tck_i) disable iff (!rst_ni || !prog_ni)
    $rose(pkt_valid_o) |-> $past(sel_cfg && tap_state == TS_SH_DR));

  // R8
  startup_state_chk: assert property (@(posedge tck_i) disable iff (!rst_ni || !prog_ni)
    startup_en_o |-> (tap_state == TS_SH_DR && !sel_cfg && !sel_bypass));

  // R10
  tdo_idle_chk: assert property (@(posedge tck_i) disable iff (!rst_ni || !prog_ni)
    (tap_state != TS_SH_IR && tap_state != TS_SH_DR) |-> !tdo_o);

endmodule

bind jcp_top jcp_chk i_jcp_chk (
  .tck_i        (tck_i),
  .rst_ni       (rst_ni),
  .prog_ni      (prog_ni),
  .tdo_o        (tdo_o),
  .pkt_valid_o  (pkt_valid_o),
  .startup_en_o (startup_en_o),
  .tap_state    (tap_state),
  .sel_cfg      (sel_cfg),
  .sel_bypass   (sel_bypass)
);

// File: tb/test_jcp_top.sv
`timescale 1ns/1ps
module test_jcp_top;

  logic       tck_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       prog_ni = 1'b1;
  logic [2:0] mode_i = 3'b101;
  logic       tms_i = 1'b1;
  logic       tdi_i = 1'b0;
  logic       tdo_o;
  logic       pkt_valid_o;
  logic [7:0] pkt_byte_o;
  logic       startup_en_o;
  logic       bscan_mode_o;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] exp_q[$];
  logic [7:0] acc = '0;
  int   acc_n = 0;
  bit   cur_cfg = 1'b0;

  always #4 tck_i = ~tck_i;

  jcp_top i_jcp_top (
    .tck_i(tck_i), .rst_ni(rst_ni), .prog_ni(prog_ni), .mode_i(mode_i),
    .tms_i(tms_i), .tdi_i(tdi_i), .tdo_o(tdo_o), .pkt_valid_o(pkt_valid_o),
    .pkt_byte_o(pkt_byte_o), .startup_en_o(startup_en_o), .bscan_mode_o(bscan_mode_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input logic tms, input logic tdi, output logic tdo_s, output logic su_s);
    tms_i = tms;
    tdi_i = tdi;
    #1;
    tdo_s = tdo_o;
    su_s  = startup_en_o;
    @(posedge tck_i);
    @(negedge tck_i);
  endtask

  task automatic step(input logic tms);
    logic a, b;
    tick(tms, 1'b0, a, b);
  endtask

  // from Run-Test-Idle: load opcode, check captured pattern (R3), return to Run-Test-Idle
  task automatic load_ir(input logic [4:0] op);
    logic t, s;
    step(1); step(1); step(0); step(0);
    for (int i = 0; i < 5; i++) begin
      tick(i == 4, op[i], t, s);
      check(t == (i == 0), "R3", t, (i == 0));
    end
    step(1); step(0);
    cur_cfg = (op == 5'b00101);
  endtask

  task automatic enter_dr();
    step(1); step(0); step(0);
  endtask

  task automatic leave_dr();
    step(1); step(0);
  endtask

  // driver: shift n bits MSB first from v; queues expected bytes
  task automatic send_bits(input logic [7:0] v, input int n, input bit exit_last, input string req);
    logic t, s;
    for (int i = 0; i < n; i++) begin
      logic b;
      b = v[7-i];
      if (cur_cfg) begin
        acc = {acc[6:0], b};
        acc_n++;
        if (acc_n == 8) begin
          exp_q.push_back(acc);
          acc_n = 0;
        end
      end
      tick(exit_last && (i == n - 1), b, t, s);
      check(!t, req, t, 0);   // R10: load path drives TDO low
    end
  endtask

  // from Run-Test-Idle: bypass scan through Shift-DR
  task automatic bypass_scan(input logic [7:0] pat, input string req);
    logic t, s, e;
    enter_dr();
    e = 1'b0;
    for (int i = 0; i < 8; i++) begin
      tick(i == 7, pat[i], t, s);
      check(t == e, req, t, e);
      e = pat[i];
    end
    leave_dr();
  endtask

  // monitor: compares strobed bytes with the queue
  initial begin
    forever begin
      @(negedge tck_i);
      #2;
      if (pkt_valid_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected packet", pkt_byte_o, 0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(pkt_byte_o == e, "R6", pkt_byte_o, e);
        end
      end
    end
  end

  task automatic run_all();
    logic t, s;
    repeat (3) @(negedge tck_i);
    rst_ni = 1'b1;
    #1;
    check(!tdo_o, "R10 reset tdo", tdo_o, 0);
    check(!pkt_valid_o, "R6 reset valid", pkt_valid_o, 0);
    check(!startup_en_o, "R8 reset startup", startup_en_o, 0);
    @(negedge tck_i);

    // R9: mode decode
    for (int m = 0; m < 8; m++) begin
      mode_i = 3'(m);
      #1;
      check(bscan_mode_o == (m == 5 || m == 1), "R9", bscan_mode_o, (m == 5 || m == 1));
    end
    @(negedge tck_i);

    step(0);
    // R5: bypass selected after reset
    bypass_scan(8'hB2, "R5 reset bypass");

    // R6: contiguous bytes, mode 000 (R9)
    mode_i = 3'b000;
    load_ir(5'b00101);
    enter_dr();
    send_bits(8'hA5, 8, 0, "R6");
    send_bits(8'hFF, 8, 0, "R6");
    send_bits(8'h00, 8, 0, "R6");
    send_bits(8'h3C, 8, 1, "R9 mode 000 load");
    leave_dr();
    repeat (2) @(negedge tck_i);
    check(exp_q.size() == 0, "R6 all bytes seen", exp_q.size(), 0);

    // R6: byte split by Pause-DR
    mode_i = 3'b101;
    enter_dr();
    send_bits(8'h96, 4, 1, "R6 pause");
    step(0); step(0); step(1); step(0);
    send_bits(8'h60, 4, 1, "R6 pause");
    leave_dr();
    repeat (2) @(negedge tck_i);
    check(exp_q.size() == 0, "R6 pause byte seen", exp_q.size(), 0);

    // R2/R4: partial byte, then five TMS-high from Pause-DR
    enter_dr();
    send_bits(8'hE0, 3, 1, "R4");
    step(0);
    for (int i = 0; i < 5; i++) step(1);
    acc_n = 0; cur_cfg = 1'b0;
    step(0);
    bypass_scan(8'h4D, "R2 R4 bypass after TLR");
    load_ir(5'b00101);
    enter_dr();
    send_bits(8'hC3, 8, 1, "R4 counter cleared");
    leave_dr();
    repeat (2) @(negedge tck_i);
    check(exp_q.size() == 0, "R4 byte seen", exp_q.size(), 0);

    // R1: program pulse in mid-byte
    enter_dr();
    send_bits(8'hA0, 3, 0, "R1");
    prog_ni = 1'b0;
    acc_n = 0; cur_cfg = 1'b0;
    for (int i = 0; i < 4; i++) begin
      tick(i[0], 1'b1, t, s);
      check(!t && !s, "R1 held", {t, s}, 0);
    end
    prog_ni = 1'b1;
    step(1);
    step(0);
    bypass_scan(8'h71, "R1 bypass after program");
    load_ir(5'b00101);
    enter_dr();
    send_bits(8'h5A, 8, 1, "R1 counter cleared");
    leave_dr();
    repeat (2) @(negedge tck_i);
    check(exp_q.size() == 0, "R1 byte seen", exp_q.size(), 0);

    // R11: BYPASS opcode and an undefined opcode
    load_ir(5'b11111);
    bypass_scan(8'h1E, "R5 bypass opcode");
    load_ir(5'b10010);
    bypass_scan(8'hD4, "R11 undefined opcode");

    // R8: start instruction
    load_ir(5'b01100);
    tick(0, 0, t, s);
    check(!s, "R8 idle", s, 0);
    step(1); step(0);
    tick(0, 0, t, s);
    check(!s, "R8 capture", s, 0);
    for (int i = 0; i < 6; i++) begin
      tick(i == 5, 1'b1, t, s);
      check(s, "R8 shift", s, 1);
      check(!t, "R10 start tdo", t, 0);
    end
    tick(1, 0, t, s);
    check(!s, "R8 exit1", s, 0);
    tick(0, 0, t, s);
    check(!s, "R8 update", s, 0);
    repeat (2) @(negedge tck_i);
    check(exp_q.size() == 0, "R7 no stray packets", exp_q.size(), 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (20000) @(posedge tck_i);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule